// File: doc/BRIEF.md
# Multi-Queue Priority Dispatcher

This block picks, once per clock, the next transmit descriptor to hand to a DMA engine. It watches up to sixteen circular descriptor queues and routes each chosen descriptor to one of eight prioritized DMA FIFO channels. Every queue is a ring of 256 entries described by a write pointer (driven by the producer on `wr_ptr_i`) and a read pointer held inside the block. A queue has work whenever its two pointers differ. A small mapping table names the single channel that each queue feeds. Several queues may share a channel, and the table can be rewritten at run time through a one-cycle write port.

Channel 7 is reserved for commands. Channels 3, 2, 1 and 0 carry voice/management, video, best-effort and background traffic, in that order of importance. Channels 4 to 6 have no traffic class and rank last. In each cycle the block finds every channel that is ready and has at least one non-empty queue mapped to it. It serves the best-ranked of those channels. Inside that channel, it grants the queue that follows, in round-robin order, the queue last granted there. The grant is registered, so `disp_valid_o` and its fields appear one clock after the inputs that caused it. In the same edge, the granted queue's read pointer advances.

The control is a two-state machine. `ST_IDLE` means no descriptor is being presented. `ST_SEND` means `disp_*` carries a descriptor in this cycle. The transition IDLE→SEND fires on a grant, SEND→SEND on a further grant, SEND→IDLE when nothing is eligible, and IDLE→IDLE otherwise.

Top module: `dsp_dispatch`

## Requirements
- R1: After reset `disp_valid_o` is 0, the state is `ST_IDLE`, and all read pointers are 0. The map sends queue q to channel q for q < 7 and to channel q mod 4 for q ≥ 7. Every channel's round-robin history points at queue 15, so the first search starts at queue 0.
- R2: A queue is non-empty exactly when its 8-bit write pointer (bits [8q+7:8q] of `wr_ptr_i`) differs from its read pointer. Both pointers wrap from 255 to 0.
- R3: A dispatch presents the granted queue's read pointer as `disp_idx_o`. That pointer then increases by one, modulo 256.
- R4: A write with `cfg_we_i` high sets queue `cfg_q_i` to feed channel `cfg_ch_i`. Grants decided in the same cycle still use the old map, and grants from the next cycle on use the new one.
- R5: If channel 7 is ready and has a non-empty queue mapped to it, it is served ahead of every other channel.
- R6: Apart from channel 7, eligible channels are served in the fixed order 3, 2, 1, 0, 6, 5, 4.
- R7: Inside a channel, the grant goes to the first non-empty mapped queue after the last one granted on that channel, searching upward and wrapping at 15.
- R8: A channel whose bit in `ch_ready_i` is 0 receives no grant, and its round-robin history stays unchanged.
- R9: At most one descriptor is dispatched per clock. A dispatch appears on the outputs in the cycle after the inputs that produced it, and a grant is issued whenever any channel is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr_i | input | 128 | Write pointer of each queue, 8 bits per queue |
| ch_ready_i | input | 8 | Per-channel FIFO ready |
| cfg_we_i | input | 1 | Map write enable |
| cfg_q_i | input | 4 | Queue whose mapping is written |
| cfg_ch_i | input | 3 | Channel assigned to that queue |
| disp_valid_o | output | 1 | Descriptor presented this cycle |
| disp_q_o | output | 4 | Queue of the presented descriptor |
| disp_ch_o | output | 3 | Channel the descriptor is steered to |
| disp_idx_o | output | 8 | Ring index of the descriptor |

## Verification
The assertions assume that the producer never moves a write pointer more than 255 entries ahead of the matching read pointer. If it did, a full ring would look empty, and the non-empty and pointer-advance properties would no longer describe the intended queue. The stimulus keeps track of each queue's occupancy from its own model and adds descriptors only while the occupancy stays below 200. Map writes, including ones that move a queue onto the command channel or onto an unused channel, arrive at arbitrary times, and the bench's expectations apply them one cycle late, as R4 requires.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } dsp_state_e;

    // Channel served at priority rank r (0 = first). The top channel is
    // commands, then traffic classes from nac-1 down to 0, then the rest downward.
    function automatic int rank_chan(input int r, input int nch, input int nac);
        if (r == 0)
            return nch - 1;
        else if (r <= nac)
            return nac - r;
        else
            return nch - 1 - (r - nac);
    endfunction

endpackage

// File: rtl/dsp_rr_pick.sv
module dsp_rr_pick #(
    parameter int NQ = 16,
    localparam int QW = $clog2(NQ)
) (
    input  logic [NQ-1:0] req_i,
    input  logic [QW-1:0] last_i,
    output logic          any_o,
    output logic [QW-1:0] gnt_q_o
);

    int idx;

    // Search starts just after the last granted queue and wraps.
    always_comb begin
        any_o   = 1'b0;
        gnt_q_o = '0;
        idx     = 0;
        for (int k = 1; k <= NQ; k++) begin
            idx = (int'(last_i) + k) % NQ;
            if (!any_o && req_i[idx]) begin
                any_o   = 1'b1;
                gnt_q_o = QW'(idx);
            end
        end
    end

endmodule

// File: rtl/dsp_chan_sel.sv
module dsp_chan_sel #(
    parameter int NCH = 8,
    parameter int NAC = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] elig_i,
    output logic           any_o,
    output logic [CW-1:0]  ch_o
);

    int c;

    always_comb begin
        any_o = 1'b0;
        ch_o  = '0;
        c     = 0;
        for (int r = 0; r < NCH; r++) begin
            c = dsp_pkg::rank_chan(r, NCH, NAC);
            if (!any_o && elig_i[c]) begin
                any_o = 1'b1;
                ch_o  = CW'(c);
            end
        end
    end

endmodule

// File: rtl/dsp_dispatch.sv
module dsp_dispatch #(
    parameter int NQ    = 16,
    parameter int NCH   = 8,
    parameter int NAC   = 4,
    parameter int NDEF  = 7,
    parameter int PTR_W = 8,
    localparam int QW     = $clog2(NQ),
    localparam int CW     = $clog2(NCH),
    localparam int CMD_CH = NCH - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NQ*PTR_W-1:0] wr_ptr_i,
    input  logic [NCH-1:0]      ch_ready_i,
    input  logic                cfg_we_i,
    input  logic [QW-1:0]       cfg_q_i,
    input  logic [CW-1:0]       cfg_ch_i,
    output logic                disp_valid_o,
    output logic [QW-1:0]       disp_q_o,
    output logic [CW-1:0]       disp_ch_o,
    output logic [PTR_W-1:0]    disp_idx_o
);

    import dsp_pkg::*;

    dsp_state_e state_q, state_d;

    logic [PTR_W-1:0] wr_a   [NQ];
    logic [PTR_W-1:0] rd_q   [NQ];
    logic [CW-1:0]    map_q  [NQ];
    logic [QW-1:0]    last_q [NCH];
    logic [NQ-1:0]    nonempty;
    logic             pick_any [NCH];
    logic [QW-1:0]    pick_q   [NCH];
    logic [NCH-1:0]   elig;
    logic             grant_v;
    logic [CW-1:0]    sel_ch;
    logic [QW-1:0]    sel_q;

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            wr_a[q]     = wr_ptr_i[q*PTR_W +: PTR_W];
            nonempty[q] = (wr_a[q] != rd_q[q]);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NQ-1:0] req;

        always_comb begin
            for (int q = 0; q < NQ; q++)
                req[q] = nonempty[q] && (map_q[q] == CW'(c));
        end

        dsp_rr_pick #(.NQ(NQ)) u_pick (
            .req_i   (req),
            .last_i  (last_q[c]),
            .any_o   (pick_any[c]),
            .gnt_q_o (pick_q[c])
        );

        // R8: a channel not granted keeps its round-robin history
        p_rr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant_v && sel_ch == CW'(c)) |=> $stable(last_q[c]))
            else $error("rr history of channel %0d moved without a grant", c);
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            elig[c] = pick_any[c] && ch_ready_i[c];
    end

    dsp_chan_sel #(.NCH(NCH), .NAC(NAC)) u_sel (
        .elig_i (elig),
        .any_o  (grant_v),
        .ch_o   (sel_ch)
    );

    assign sel_q = pick_q[sel_ch];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = grant_v ? ST_SEND : ST_IDLE;
            ST_SEND: state_d = grant_v ? ST_SEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Queue pointers, map and round-robin history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                rd_q[q]  <= '0;
                map_q[q] <= (q < NDEF) ? CW'(q) : CW'(q % NAC);
            end
            for (int c = 0; c < NCH; c++)
                last_q[c] <= QW'(NQ - 1);
        end else begin
            if (grant_v) begin
                rd_q[sel_q]    <= rd_q[sel_q] + 1'b1;
                last_q[sel_ch] <= sel_q;
            end
            if (cfg_we_i)
                map_q[cfg_q_i] <= cfg_ch_i;
        end
    end

    // Outputs
    assign disp_valid_o = (state_q == ST_SEND);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q_o   <= '0;
            disp_ch_o  <= '0;
            disp_idx_o <= '0;
        end else if (grant_v) begin
            disp_q_o   <= sel_q;
            disp_ch_o  <= sel_ch;
            disp_idx_o <= rd_q[sel_q];
        end
    end

    p_grant_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_v |-> ch_ready_i[sel_ch])
        else $error("grant to a channel that is not ready");

    p_grant_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_v |-> (wr_a[sel_q] != rd_q[sel_q]) && (map_q[sel_q] == sel_ch))
        else $error("grant to an empty or unmapped queue");

    p_cmd_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        elig[CMD_CH] |-> grant_v && (sel_ch == CW'(CMD_CH)))
        else $error("command channel not served first");

    p_top_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elig[NAC-1] && !elig[CMD_CH]) |-> (sel_ch == CW'(NAC-1)))
        else $error("highest traffic class passed over");

    p_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |=> disp_valid_o)
        else $error("eligible channel left without dispatch");

    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> rd_q[disp_q_o] == PTR_W'(disp_idx_o + 1'b1))
        else $error("read pointer did not advance past dispatched index");

endmodule

// File: tb/dsp_dispatch_tb_top.sv
`timescale 1ns/1ps
module dsp_dispatch_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] wr_ptr_i = '0;
    logic [7:0]   ch_ready_i = '0;
    logic         cfg_we_i = 1'b0;
    logic [3:0]   cfg_q_i = '0;
    logic [2:0]   cfg_ch_i = '0;
    logic         disp_valid_o;
    logic [3:0]   disp_q_o;
    logic [2:0]   disp_ch_o;
    logic [7:0]   disp_idx_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dsp_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .wr_ptr_i(wr_ptr_i), .ch_ready_i(ch_ready_i),
        .cfg_we_i(cfg_we_i), .cfg_q_i(cfg_q_i), .cfg_ch_i(cfg_ch_i),
        .disp_valid_o(disp_valid_o), .disp_q_o(disp_q_o),
        .disp_ch_o(disp_ch_o), .disp_idx_o(disp_idx_o)
    );

    // Reference model state
    int m_rd [16];
    int m_wr [16];
    int m_map[16];
    int m_last[8];
    bit e_valid;
    int e_q, e_ch, e_idx;

    function automatic int prio_ch(input int r);
        case (r)
            0: return 7;
            1: return 3;
            2: return 2;
            3: return 1;
            4: return 0;
            5: return 6;
            6: return 5;
            default: return 4;
        endcase
    endfunction

    function automatic int occ(input int q);
        return (m_wr[q] - m_rd[q] + 256) % 256;
    endfunction

    task automatic push(input int q, input int n);
        if (occ(q) + n <= 200) m_wr[q] = (m_wr[q] + n) % 256;
    endtask

    task automatic compare(input string tag);
        n_tests++;
        if (disp_valid_o !== e_valid ||
            (e_valid && (disp_q_o !== 4'(e_q) || disp_ch_o !== 3'(e_ch) ||
                         disp_idx_o !== 8'(e_idx)))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b q=%0d ch=%0d idx=%0d exp v=%0b q=%0d ch=%0d idx=%0d",
                     tag, disp_valid_o, disp_q_o, disp_ch_o, disp_idx_o,
                     e_valid, e_q, e_ch, e_idx);
        end
    endtask

    // One cycle: check previous expectation, drive new inputs, predict next.
    task automatic step(input logic [7:0] rdy, input bit we, input int cq, input int cc,
                        input string tag);
        bit found;
        int ch;
        @(negedge clk);
        compare(tag);
        ch_ready_i = rdy;
        cfg_we_i   = we;
        cfg_q_i    = 4'(cq);
        cfg_ch_i   = 3'(cc);
        for (int q = 0; q < 16; q++) wr_ptr_i[q*8 +: 8] = 8'(m_wr[q]);
        found = 0;
        ch = 0;
        for (int r = 0; r < 8; r++) begin
            int c;
            bit has;
            c = prio_ch(r);
            has = 0;
            for (int q = 0; q < 16; q++)
                if (m_map[q] == c && occ(q) != 0) has = 1;
            if (!found && rdy[c] && has) begin
                found = 1;
                ch = c;
            end
        end
        e_valid = found;
        if (found) begin
            bit got;
            got = 0;
            for (int k = 1; k <= 16; k++) begin
                int q;
                q = (m_last[ch] + k) % 16;
                if (!got && m_map[q] == ch && occ(q) != 0) begin
                    got = 1;
                    e_q = q;
                end
            end
            e_ch  = ch;
            e_idx = m_rd[e_q];
            m_rd[e_q]  = (m_rd[e_q] + 1) % 256;
            m_last[ch] = e_q;
        end
        if (we) m_map[cq] = cc;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got hang exp completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int q = 0; q < 16; q++) begin
            m_rd[q] = 0;
            m_wr[q] = 0;
            m_map[q] = (q < 7) ? q : q % 4;
        end
        for (int c = 0; c < 8; c++) m_last[c] = 15;
        e_valid = 0; e_q = 0; e_ch = 0; e_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_tests++;
        if (disp_valid_o !== 1'b0 || disp_q_o !== 4'd0 || disp_ch_o !== 3'd0 ||
            disp_idx_o !== 8'd0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%0b q=%0d ch=%0d idx=%0d exp 0 0 0 0",
                     disp_valid_o, disp_q_o, disp_ch_o, disp_idx_o);
        end
        step(8'hFF, 0, 0, 0, "R1 idle");

        // R1 default map, R6 order across channels, R9 one per cycle
        for (int q = 0; q < 16; q++) push(q, 1);
        for (int i = 0; i < 20; i++) step(8'hFF, 0, 0, 0, "R1/R6/R9 default map");

        // R7 round robin inside a channel: queues 1, 8, 12 on channel 1
        step(8'hFF, 1, 8, 1, "R4 map write");
        step(8'hFF, 1, 12, 1, "R4 map write");
        push(1, 4); push(8, 4); push(12, 4);
        for (int i = 0; i < 16; i++) step(8'hFF, 0, 0, 0, "R7 round robin");

        // R8 channel not ready: channel 1 blocked, channel 0 served
        push(1, 3); push(8, 3); push(0, 3);
        for (int i = 0; i < 6; i++) step(8'hFD, 0, 0, 0, "R8 blocked channel");
        for (int i = 0; i < 10; i++) step(8'hFF, 0, 0, 0, "R8 resume history");

        // R5 command channel preempts: queue 4 moved to channel 7
        step(8'hFF, 1, 4, 7, "R4 map to command");
        push(4, 5); push(3, 5); push(2, 5);
        for (int i = 0; i < 18; i++) step(8'hFF, 0, 0, 0, "R5 command first");

        // R4 remap in the same cycle as a grant decision
        push(5, 4);
        step(8'hFF, 1, 5, 3, "R4 same-cycle remap");
        for (int i = 0; i < 8; i++) step(8'hFF, 0, 0, 0, "R4 new map used");

        // R2/R3 wrap of 8-bit pointers on queue 2
        for (int i = 0; i < 320; i++) begin
            push(2, 1);
            step(8'hFF, 0, 0, 0, "R2/R3 pointer wrap");
        end

        // Mixed traffic, R6 ordering under random readiness
        for (int i = 0; i < 4000; i++) begin
            int q;
            logic [7:0] rdy;
            bit we;
            q = int'($urandom_range(15));
            push(q, int'($urandom_range(3)));
            rdy = 8'($urandom);
            we = ($urandom_range(19) == 0);
            step(rdy, we, int'($urandom_range(15)), int'($urandom_range(7)),
                 "R6/R7/R8 mixed");
        end
        for (int i = 0; i < 600; i++) step(8'hFF, 0, 0, 0, "R9 drain");
        step(8'hFF, 0, 0, 0, "R9 drained idle");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule